// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This block sits between a 32-bit core and a small byte-addressable data store. Each request carries a base register value, a signed 16-bit displacement, an operation code and store data. The unit adds the sign-extended displacement to the base to form the effective address. It then performs a word or byte load or store against an internal synchronous memory.

Results come back exactly one clock after the request, marked by a one-cycle done pulse. A byte load returns a sign-extended value. A byte store changes exactly one location. Words are big-endian. A word access whose effective address is not a multiple of 4 is refused: memory is left untouched and a bus error flag is raised alongside done.

The memory is split into four byte lanes, each a plain synchronous RAM, so that a word moves in one access.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is base plus the sign-extended 16-bit displacement, modulo 2^32. The low MEM_AW bits of this address pick the byte location, so addresses that differ only above bit MEM_AW-1 alias to the same location.
- R2: Operation encoding on `req_op` is: 2'b00 byte load, 2'b01 word load, 2'b10 byte store, 2'b11 word store.
- R3: A byte load returns the addressed byte in bits 7:0, with bits 31:8 all equal to bit 7 of that byte.
- R4: A byte store writes `wdata[7:0]` to the addressed location only. The other three bytes of the same word keep their contents.
- R5: Every cycle with `req_valid` high is followed, one clock later, by exactly one cycle of `done` high. `done` is never high without such a request. Requests may arrive on back-to-back cycles.
- R6: A word load or word store whose effective address has bits 1:0 not equal to 2'b00 returns `bus_err` high together with `done`, and `rdata` zero. Byte accesses never raise `bus_err`.
- R7: A misaligned word store leaves every memory location unchanged.
- R8: Words are big-endian: the byte at the word's lowest address is bits 31:24 and the byte at address+3 is bits 7:0, for both word loads and word stores.
- R9: While and just after synchronous reset, `done` and `bus_err` are low. Stores and faulted requests return `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | Operation code (see R2) |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| wdata | input | 32 | Store data |
| rdata | output | 32 | Load result, valid with done |
| done | output | 1 | Result strobe, one cycle after request |
| bus_err | output | 1 | Misaligned word access flag, valid with done |

## Verification
The assertions assume that `req_op` and the address inputs are known whenever `req_valid` is high. They also assume that `rst` is released only at a clock edge. The bench drives every input on the falling edge and keeps `req_valid` low during reset. It fills the whole memory with word stores before any load, so every load reads a location whose value the scoreboard model knows.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LDB = 2'b00,
    OP_LDW = 2'b01,
    OP_STB = 2'b10,
    OP_STW = 2'b11
  } lsu_op_e;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  function automatic logic op_is_word(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_store(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic              is_word,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    ea         = base + disp_ext;
    misaligned = is_word && (ea[1:0] != 2'b00);
  end
endmodule

// File: rtl/lsu_bank.sv
module lsu_bank #(
  parameter int ROW_AW = 6,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] row,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout
);
  localparam int DEPTH = 1 << ROW_AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= din;
    dout <= mem[row];
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              bus_err
);
  localparam int ROW_AW = MEM_AW - 2;

  logic [ADDR_W-1:0] ea;
  logic              misal;
  logic              is_word;
  logic              is_store;
  logic [1:0]        lane;
  logic [ROW_AW-1:0] row;
  logic [LANE_W-1:0] lane_q [LANES];

  assign is_word  = op_is_word(req_op);
  assign is_store = op_is_store(req_op);
  assign lane     = ea[1:0];
  assign row      = ea[MEM_AW-1:2];

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) agen_i (
    .base(base), .disp(offset), .is_word(is_word),
    .ea(ea), .misaligned(misal)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic              we_k;
    logic [LANE_W-1:0] din_k;
    always_comb begin
      we_k  = req_valid && is_store && !misal && (is_word || lane == 2'(k));
      din_k = is_word ? wdata[DATA_W-1-LANE_W*k -: LANE_W] : wdata[LANE_W-1:0];
    end
    lsu_bank #(.ROW_AW(ROW_AW), .W(LANE_W)) bank_i (
      .clk(clk), .we(we_k), .row(row), .din(din_k), .dout(lane_q[k])
    );
  end

  logic       ldw_q, ldb_q;
  logic [1:0] lane_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      bus_err    <= 1'b0;
      ldw_q      <= 1'b0;
      ldb_q      <= 1'b0;
      lane_sel_q <= 2'b00;
    end else begin
      done       <= req_valid;
      bus_err    <= req_valid && misal;
      ldw_q      <= req_valid && !is_store && is_word && !misal;
      ldb_q      <= req_valid && !is_store && !is_word;
      lane_sel_q <= lane;
    end
  end

  logic [LANE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = lane_q[lane_sel_q];
    if (ldw_q)
      rdata = {lane_q[0], lane_q[1], lane_q[2], lane_q[3]};
    else if (ldb_q)
      rdata = {{(DATA_W-LANE_W){sel_byte[LANE_W-1]}}, sel_byte};
    else
      rdata = '0;
  end

  // R5: a request yields done on the next cycle
  a_r5_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);
  // R5: no done without a request one cycle earlier
  a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done);
  // R6: misaligned word access faults on the next cycle
  a_r6_misaligned_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_word && ea[1:0] != 2'b00) |=> (bus_err && done));
  // R6: byte accesses never fault
  a_r6_byte_no_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !is_word) |=> !bus_err);
  // R6: faulted results carry zero data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (rdata == '0));
  // R7: a faulted request writes no lane
  a_r7_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
    misal |-> !(g_lane[0].we_k || g_lane[1].we_k || g_lane[2].we_k || g_lane[3].we_k));
  // R4: a byte store enables exactly one lane
  a_r4_single_lane: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_store && !is_word) |->
      $countones({g_lane[0].we_k, g_lane[1].we_k, g_lane[2].we_k, g_lane[3].we_k}) == 1);
endmodule

// File: tb/lsu_unit_tb.sv
module lsu_unit_tb_top;
  localparam int MEM_AW = 8;
  localparam int MSIZE  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        done;
  logic        bus_err;

  always #10 clk = ~clk;

  lsu_unit #(.MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .base(base), .offset(offset), .wdata(wdata),
    .rdata(rdata), .done(done), .bus_err(bus_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  mdl [MSIZE];
  logic [32:0] exp_q [$];
  string       tag_q [$];
  bit          finished = 0;

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual err=%0b data=%08h expected err=%0b data=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // driver: one request on one cycle, expectation pushed from the model
  task automatic issue(input logic [1:0] op, input logic [31:0] b,
                       input logic [15:0] d, input logic [31:0] wd, input string tag);
    logic [31:0] ea;
    logic [MEM_AW-1:0] a;
    logic [32:0] e;
    ea = b + {{16{d[15]}}, d};
    a  = ea[MEM_AW-1:0];
    e  = '0;
    if (op[0] && ea[1:0] != 2'b00) e = {1'b1, 32'h0};
    else case (op)
      2'b00: e = {1'b0, {{24{mdl[a][7]}}, mdl[a]}};
      2'b01: e = {1'b0, mdl[a], mdl[a+1], mdl[a+2], mdl[a+3]};
      2'b10: mdl[a] = wd[7:0];
      default: begin
        mdl[a] = wd[31:24]; mdl[a+1] = wd[23:16];
        mdl[a+2] = wd[15:8]; mdl[a+3] = wd[7:0];
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = op; base = b; offset = d; wdata = wd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (exp_q.size() == 0) begin
          check("R5 spurious done", {bus_err, rdata}, 33'h1_FFFF_FFFF);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {bus_err, rdata}, e);
        end
      end else if (!rst && exp_q.size() != 0 && !req_valid) begin
        check("R5 missing done", {1'b0, 32'h0}, 33'h1_0000_0000);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", {bus_err, 31'h0, done}, 33'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", {bus_err, 31'h0, done}, 33'h0);

    // fill memory with word stores (R8 layout), back to back (R5)
    for (int i = 0; i < MSIZE / 4; i++)
      issue(2'b11, 32'h0, 16'(i * 4), 32'hA000_0000 | (i * 32'h0101_0103), "R2 fill store");
    idle();

    issue(2'b01, 32'h0000_0100, 16'hFF08, 32'h0, "R1 negative displacement word load");
    issue(2'b01, 32'h0000_0000, 16'h0008, 32'h0, "R1 third word at offset 8");
    issue(2'b11, 32'h0000_0010, 16'h0000, 32'h80FF_7F01, "R8 word store");
    issue(2'b01, 32'h0000_0010, 16'h0000, 32'h0, "R8 big-endian word load");
    issue(2'b00, 32'h0000_0010, 16'h0000, 32'h0, "R3 byte 0x80 sign extends");
    issue(2'b00, 32'h0000_0010, 16'h0001, 32'h0, "R3 byte 0xFF sign extends");
    issue(2'b00, 32'h0000_0010, 16'h0002, 32'h0, "R3 byte 0x7F stays positive");
    issue(2'b00, 32'h0000_0013, 16'h0000, 32'h0, "R3 byte 0x01 lowest lane");
    idle();
    issue(2'b10, 32'h0000_0014, 16'h0001, 32'hAABB_CC85, "R4 byte store");
    issue(2'b01, 32'h0000_0014, 16'h0000, 32'h0, "R4 neighbours unchanged");
    issue(2'b00, 32'h0000_0016, 16'hFFFF, 32'h0, "R4 stored byte reads back");
    issue(2'b11, 32'h0000_0018, 16'h0002, 32'h1234_5678, "R6 misaligned word store faults");
    issue(2'b01, 32'h0000_0018, 16'h0000, 32'h0, "R7 memory unchanged after fault");
    issue(2'b11, 32'h0000_001C, 16'h0003, 32'hDEAD_BEEF, "R6 misaligned store by 3");
    issue(2'b01, 32'h0000_001C, 16'h0000, 32'h0, "R7 word unchanged after fault");
    issue(2'b00, 32'h0000_001C, 16'h0003, 32'h0, "R7 byte unchanged after fault");
    issue(2'b01, 32'h0000_0020, 16'h0001, 32'h0, "R6 misaligned word load faults");
    issue(2'b01, 32'h0000_0021, 16'hFFFF, 32'h0, "R6 aligned after offset sum");
    issue(2'b00, 32'h0000_0021, 16'h0000, 32'h0, "R6 byte load at odd address no fault");
    issue(2'b10, 32'h0000_0023, 16'h0000, 32'h0000_00F0, "R6 byte store odd no fault");
    issue(2'b01, 32'h0000_0020, 16'h0000, 32'h0, "R4 low lane store visible");
    issue(2'b01, 32'hFFFF_FF00, 16'h0004, 32'h0, "R1 address aliasing");
    issue(2'b11, 32'h7FFF_FFF0, 16'h8010, 32'h0BAD_F00D, "R1 wrap store");
    issue(2'b01, 32'h0000_0000, 16'h0000, 32'h0, "R1 wrap store lands at 0");
    idle();
    repeat (3) @(negedge clk);
    check("R5 all results returned", {1'b0, 32'(exp_q.size())}, 33'h0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R5 watchdog: actual hung expected finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule